// File: doc/BRIEF.md
# Serial EEPROM Byte Fetch Sequencer

This block reads a short run of bytes, typically a station MAC address, out of a small serial EEPROM over a four-wire link. The link has an active-low select, a serial clock, serial data toward the memory and serial data back from it. The host pulses `start` with a starting byte offset and a byte count. The sequencer first sends two clock pulses with the memory deselected. It then performs one complete command transaction per byte: select, the read opcode, the 8-bit offset, 8 returned data bits, and deselect. The offset advances by one between transactions. Each returned byte appears with a one-cycle strobe, and `done` marks the end of the run.

A second mode fetches the memory's status byte. This mode uses a different opcode, has no address phase, and always performs exactly one transaction. The serial clock is an ordinary registered output. Each of its half-periods lasts `HALF_CYC` system clock cycles. The returned data line passes through a synchronizer before it is sampled.

Top module: `eeprom_seq_reader`

## Requirements
- R1: After reset, `ee_cs_n` is high, `ee_sck`, `ee_mosi`, `busy`, `done` and `rd_valid` are low.
- R2: An accepted start first produces two clock pulses (`ee_sck` high then low, twice) while `ee_cs_n` stays high, before `ee_cs_n` first falls.
- R3: A data-mode transaction shifts out opcode 8'h03 and then the 8-bit byte address, both MSB first. `ee_mosi` never changes while `ee_sck` is high, so every bit is set up in the low phase and taken on the rising edge.
- R4: Eight data bits are taken from `ee_miso` MSB first, each one late in the low phase that precedes a rising edge. The collected byte appears on `rd_data` with a one-cycle `rd_valid` pulse, which comes while `ee_cs_n` is high after the byte.
- R5: Every high phase of `ee_sck` lasts exactly `HALF_CYC` system clock cycles. Every low phase between two bits of a transaction also lasts exactly `HALF_CYC` cycles.
- R6: `ee_cs_n` changes only in cycles where `ee_sck` is low. Between two transactions it stays high for at least 2*`HALF_CYC` cycles.
- R7: A data-mode run with count N>0 performs N transactions at addresses offset, offset+1, … modulo 256, and produces N bytes in that order.
- R8: In status mode, one transaction sends opcode 8'h05 followed directly by 8 data bits (16 clock pulses in total). Offset and count are ignored.
- R9: A data-mode start with count 0 produces no serial activity. `done` pulses in the cycle after the start, and `busy` stays low.
- R10: `busy` is high from the cycle after an accepted start until the run completes. `done` pulses in the first cycle with `busy` low again. A start while `busy` is high is ignored, and the select and clock rest high and low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| status_mode | input | 1 | 1: read the status byte; 0: read data bytes |
| start_addr | input | ADDR_W (8) | First byte offset of a data run |
| byte_count | input | CNT_W (8) | Number of bytes in a data run |
| ee_cs_n | output | 1 | Memory select, active low |
| ee_sck | output | 1 | Serial clock to the memory |
| ee_mosi | output | 1 | Serial data to the memory |
| ee_miso | input | 1 | Serial data from the memory |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Byte returned by the last transaction |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Some properties are checked every cycle by assertions. These are the link-level rules: `ee_mosi` holds still while `ee_sck` is high, `ee_cs_n` moves only with the clock low, every high phase lasts exactly `HALF_CYC`, the lines rest whenever the block is idle, and `rd_valid` and `done` are single pulses in legal states. Other properties need a memory on the far side, so only the bench scenarios show them. These are the opcode and address contents, the two-pulse preamble, the data values and their MSB-first order, address wrap past 8'hFF, the gap length between transactions, status mode ignoring offset and count, the count-zero shortcut, and a start that arrives mid-run being dropped.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } rd_state_e;

  localparam int OPC_W  = 8;
  localparam int DATA_W = 8;

  localparam logic [OPC_W-1:0] OPC_READ = 8'h03;
  localparam logic [OPC_W-1:0] OPC_STAT = 8'h05;

endpackage

// File: rtl/eeprom_half_timer.sv
module eeprom_half_timer #(
  parameter int HALF_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] ctr_q, ctr_d;

  assign tick = run && (ctr_q == CW'(HALF_CYC - 1));

  always_comb begin
    ctr_d = ctr_q;
    if (!run || tick) begin
      ctr_d = '0;
    end else begin
      ctr_d = ctr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else begin
      ctr_q <= ctr_d;
    end
  end

endmodule

// File: rtl/eeprom_shift_path.sv
module eeprom_shift_path #(
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] load_word,
  input  logic             shift_out,
  input  logic             sample,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [7:0]       in_byte
);

  logic [OUT_W-1:0] out_q, out_d;
  logic [7:0]       in_q, in_d;
  logic             miso_s;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= miso_i;
      end
      assign miso_s = s_q;
    end else begin : g_sync_multi
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], miso_i};
      end
      assign miso_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    out_d = out_q;
    if (load) begin
      out_d = load_word;
    end else if (shift_out) begin
      out_d = {out_q[OUT_W-2:0], 1'b0};
    end
  end

  always_comb begin
    in_d = in_q;
    if (sample) begin
      in_d = {in_q[6:0], miso_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      out_q <= out_d;
      in_q  <= in_d;
    end
  end

  assign mosi_o  = out_q[OUT_W-1];
  assign in_byte = in_q;

endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_CYC    = 500,
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              status_mode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              ee_cs_n,
  output logic              ee_sck,
  output logic              ee_mosi,
  input  logic              ee_miso,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done
);

  localparam int OUT_W    = OPC_W + ADDR_W;
  localparam int TOT_BITS = OUT_W + DATA_W;
  localparam int BW       = $clog2(TOT_BITS);

  rd_state_e         st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              stat_q, stat_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic              valid_q, valid_d;
  logic              done_q, done_d;
  logic [7:0]        data_q, data_d;

  logic              tick;
  logic              load, shift_out, sample;
  logic [OUT_W-1:0]  load_word;
  logic [7:0]        in_byte;
  logic [BW-1:0]     first_in, last_bit;

  eeprom_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q != ST_IDLE),
    .tick  (tick)
  );

  eeprom_shift_path #(.OUT_W(OUT_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .shift_out (shift_out),
    .sample    (sample),
    .miso_i    (ee_miso),
    .mosi_o    (ee_mosi),
    .in_byte   (in_byte)
  );

  // Bit window of the returned byte depends on whether an address phase exists.
  assign first_in  = stat_q ? BW'(OPC_W)              : BW'(OUT_W);
  assign last_bit  = stat_q ? BW'(OPC_W + DATA_W - 1) : BW'(TOT_BITS - 1);
  assign load_word = stat_q ? {OPC_STAT, {ADDR_W{1'b0}}} : {OPC_READ, addr_q};

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    bit_d     = bit_q;
    left_d    = left_q;
    addr_d    = addr_q;
    stat_d    = stat_q;
    sck_d     = sck_q;
    cs_n_d    = cs_n_q;
    data_d    = data_q;
    valid_d   = 1'b0;
    done_d    = 1'b0;
    load      = 1'b0;
    shift_out = 1'b0;
    sample    = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!status_mode && (byte_count == '0)) begin
            done_d = 1'b1;
          end else begin
            st_d   = ST_PRE;
            ph_d   = 2'd0;
            sck_d  = 1'b1;
            cs_n_d = 1'b1;
            stat_d = status_mode;
            addr_d = start_addr;
            left_d = status_mode ? CNT_W'(1) : byte_count;
          end
        end
      end

      ST_PRE: begin
        if (tick) begin
          if (ph_q == 2'd3) begin
            st_d   = ST_XFER;
            ph_d   = 2'd0;
            bit_d  = '0;
            cs_n_d = 1'b0;
            sck_d  = 1'b0;
            load   = 1'b1;
          end else begin
            ph_d  = ph_q + 2'd1;
            sck_d = ph_q[0];
          end
        end
      end

      ST_XFER: begin
        if (tick) begin
          if (ph_q == 2'd0) begin
            ph_d   = 2'd1;
            sck_d  = 1'b1;
            sample = (bit_q >= first_in);
          end else begin
            sck_d     = 1'b0;
            shift_out = 1'b1;
            if (bit_q == last_bit) begin
              st_d    = ST_GAP;
              ph_d    = 2'd0;
              cs_n_d  = 1'b1;
              valid_d = 1'b1;
              data_d  = in_byte;
              left_d  = left_q - 1'b1;
              addr_d  = addr_q + 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
              ph_d  = 2'd0;
            end
          end
        end
      end

      ST_GAP: begin
        if (tick) begin
          if (ph_q == 2'd0) begin
            ph_d = 2'd1;
          end else if (left_q == '0) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d   = ST_XFER;
            ph_d   = 2'd0;
            bit_d  = '0;
            cs_n_d = 1'b0;
            load   = 1'b1;
          end
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= 2'd0;
      bit_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      stat_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
      stat_q  <= stat_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      data_q  <= data_d;
    end
  end

  assign ee_cs_n  = cs_n_q;
  assign ee_sck   = sck_q;
  assign rd_valid = valid_q;
  assign rd_data  = data_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk #(
  parameter int HALF_CYC = 500
) (
  input logic clk,
  input logic rst_n,
  input logic ee_cs_n,
  input logic ee_sck,
  input logic ee_mosi,
  input logic busy,
  input logic done,
  input logic rd_valid
);

  localparam int RW = $clog2(HALF_CYC + 2) + 1;

  logic [RW-1:0] run_q;
  logic          sck_prev_q;
  logic          cs_prev_q;

  // Length of the level ee_sck held before the current cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= ee_sck;
      cs_prev_q  <= ee_cs_n;
      if (ee_sck != sck_prev_q) begin
        run_q <= RW'(1);
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sck |-> $stable(ee_mosi));

  a_r5_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_sck && sck_prev_q) |-> (run_q == RW'(HALF_CYC)));

  a_r6_cs_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs_n != cs_prev_q) |-> !ee_sck);

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_valid_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && ee_cs_n));

  a_r10_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ee_cs_n && !ee_sck));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_valid));

endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ee_cs_n  (ee_cs_n),
  .ee_sck   (ee_sck),
  .ee_mosi  (ee_mosi),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid)
);

// File: tb/eeprom_seq_reader_test.sv
module eeprom_seq_reader_test;

  localparam int HALF = 4;
  localparam logic [7:0] STAT_VAL = 8'h4C;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, status_mode;
  logic [7:0] start_addr, byte_count;
  logic       ee_cs_n, ee_sck, ee_mosi;
  logic       ee_miso;
  logic       rd_valid, busy, done;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  eeprom_seq_reader #(.HALF_CYC(HALF), .ADDR_W(8), .CNT_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .status_mode(status_mode),
    .start_addr(start_addr), .byte_count(byte_count),
    .ee_cs_n(ee_cs_n), .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done)
  );

  function automatic logic [7:0] mem_at(input logic [7:0] a);
    return 8'(a * 8'd29 + 8'd7) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Serial memory model and link monitors
  logic       miso_m = 1'b0;
  int         rise_n = 0;
  logic [15:0] cap = '0;
  logic [7:0] m_op = '0, m_addr = '0, dv;
  bit         in_tx = 0;
  int         tx_n = 0, pre_rises = 0, bad_half = 0, min_gap = 0;
  int         hi_sck = 0, lo_sck = 0, cs_hi_run = 0;
  logic [7:0] tx_op[64], tx_addr[64];
  int         tx_rise[64];
  int         ngot = 0;
  logic [7:0] got[64];

  assign ee_miso = miso_m;

  always @(posedge clk) begin
    if (ee_sck === 1'b1) begin hi_sck++; lo_sck = 0; end
    else begin lo_sck++; hi_sck = 0; end
    if (ee_cs_n === 1'b1) cs_hi_run++;
    else cs_hi_run = 0;
  end

  always @(negedge ee_cs_n) begin
    if (tx_n > 0 && cs_hi_run < min_gap) min_gap = cs_hi_run;
    in_tx = 1; rise_n = 0; cap = '0;
  end

  always @(posedge ee_sck) begin
    if (ee_cs_n === 1'b0) begin
      if (rise_n > 0 && lo_sck != HALF) bad_half++;
      if (rise_n < 16) cap = {cap[14:0], ee_mosi};
      rise_n++;
      if (rise_n == 8)  m_op = cap[7:0];
      if (rise_n == 16) m_addr = cap[7:0];
    end else begin
      pre_rises++;
    end
  end

  always @(negedge ee_sck) begin
    if (hi_sck != HALF) bad_half++;
    if (ee_cs_n === 1'b0) begin
      if (m_op == 8'h05 && rise_n >= 8 && rise_n < 16) miso_m = STAT_VAL[15 - rise_n];
      else if (m_op == 8'h03 && rise_n >= 16 && rise_n < 24) begin
        dv = mem_at(m_addr);
        miso_m = dv[23 - rise_n];
      end else miso_m = 1'b0;
    end
  end

  always @(posedge ee_cs_n) begin
    if (in_tx) begin
      in_tx = 0;
      if (tx_n < 64) begin
        tx_op[tx_n] = m_op; tx_addr[tx_n] = m_addr; tx_rise[tx_n] = rise_n;
      end
      tx_n++;
      miso_m = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rd_valid === 1'b1) begin
      if (ngot < 64) got[ngot] = rd_data;
      ngot++;
    end
  end

  task automatic run_op(input bit stat, input logic [7:0] a, input int cnt, input bit poke);
    int exp_n;
    int guard;
    exp_n = stat ? 1 : cnt;
    ngot = 0; tx_n = 0; pre_rises = 0; bad_half = 0; min_gap = 1000000;
    @(negedge clk);
    start = 1'b1; status_mode = stat; start_addr = a; byte_count = 8'(cnt);
    @(negedge clk);
    start = 1'b0;
    if (exp_n == 0) begin
      chk(done === 1'b1 && busy === 1'b0, "R9 count zero done", int'(done), 1);
    end else begin
      chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
      // inputs changed after acceptance must not matter
      status_mode = ~stat; start_addr = ~a; byte_count = 8'h09;
    end
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 20000, "watchdog", guard, 0);
    chk(busy === 1'b0, "R10 busy low with done", int'(busy), 0);
    chk(tx_n == exp_n, "R7 transaction count", tx_n, exp_n);
    chk(ngot == exp_n, "R7 byte count", ngot, exp_n);
    if (exp_n == 0) begin
      chk(pre_rises == 0, "R9 no clock pulses", pre_rises, 0);
    end else begin
      chk(pre_rises == 2, "R2 preamble pulses", pre_rises, 2);
      chk(bad_half == 0, "R5 half-period errors", bad_half, 0);
    end
    if (exp_n > 1) chk(min_gap >= 2 * HALF, "R6 deselect gap", min_gap, 2 * HALF);
    for (int i = 0; i < exp_n && i < 64 && i < tx_n && i < ngot; i++) begin
      if (stat) begin
        chk(tx_op[i] == 8'h05, "R8 status opcode", int'(tx_op[i]), 5);
        chk(tx_rise[i] == 16, "R8 status clock pulses", tx_rise[i], 16);
        chk(got[i] == STAT_VAL, "R8 status byte", int'(got[i]), int'(STAT_VAL));
      end else begin
        chk(tx_op[i] == 8'h03, "R3 read opcode", int'(tx_op[i]), 3);
        chk(tx_addr[i] == 8'(a + i), "R3 R7 address", int'(tx_addr[i]), int'(8'(a + i)));
        chk(tx_rise[i] == 24, "R4 data clock pulses", tx_rise[i], 24);
        chk(got[i] == mem_at(8'(a + i)), "R4 data byte", int'(got[i]), int'(mem_at(8'(a + i))));
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R10 done single pulse", int'(done), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && ngot == exp_n, "R10 start while busy ignored", ngot, exp_n);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; status_mode = 1'b0; start_addr = '0; byte_count = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(ee_cs_n === 1'b1 && ee_sck === 1'b0 && ee_mosi === 1'b0, "R1 link lines in reset",
        int'({ee_cs_n, ee_sck, ee_mosi}), 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R1 status after reset",
        int'({busy, done, rd_valid}), 0);
    chk(ee_cs_n === 1'b1 && ee_sck === 1'b0, "R1 idle lines", int'({ee_cs_n, ee_sck}), 2);

    run_op(1'b0, 8'h10, 1, 1'b0);
    run_op(1'b0, 8'hFE, 4, 1'b0);
    run_op(1'b1, 8'h33, 7, 1'b0);
    run_op(1'b1, 8'h00, 0, 1'b0);
    run_op(1'b0, 8'h40, 0, 1'b0);
    run_op(1'b0, 8'h80, 3, 1'b1);
    for (int k = 0; k < 8; k++) begin
      bit s;
      s = (($urandom % 4) == 0);
      run_op(s, 8'($urandom), 1 + int'($urandom % 5), 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule